// File: doc/BRIEF.md
# Bus-Kicked Watchdog Reset Generator

This block drives the processor's halt and reset lines, both active low and always together. It holds both lines low for a fixed number of clock cycles once the synchronous power-on reset input is released. After that it watches for a periodic "kick", which is a processor write cycle to one fixed register address. The block decodes the kick itself from the address bus and the write strobe. A frame-rate tick advances a timeout counter, and each kick clears it. If the counter reaches its limit before a kick arrives, the block pulls halt and reset low again for a programmable number of cycles. It then releases them and starts timing from zero.

A board strap input, `wd_en`, is high when the board leaves it open. Tying it low stops the timeout and keeps the counter at zero, but the power-on pulse still happens. The data bus is not routed to the block, so the value carried by a kick write has no effect.

The controller has three states. `ST_POR` is the power-on pulse and `ST_RUN` is the watching state. `ST_FIRE` is the pulse that a missed kick causes. There are three named transitions. `POR_DONE` goes from `ST_POR` to `ST_RUN` when the power-on length has elapsed. `EXPIRE` goes from `ST_RUN` to `ST_FIRE` on the tick that fills the window. `FIRE_DONE` goes from `ST_FIRE` to `ST_RUN` when the pulse length has elapsed. A high `rst` forces `ST_POR` from any state.

Top module: `wdog_rst_gen`

## Requirements
- R1: While `rst` is sampled high, `cpu_reset_n` and `cpu_halt_n` are both 0 after the next clock edge.
- R2: After `rst` is released, both outputs stay 0 for exactly `POR_CYCLES` clock cycles and then go to 1.
- R3: In the run state, suppose `TIMEOUT_TICKS` cycles with `frame_tick`=1 occur with no kick since the last clear. Both outputs go to 0 at the edge that samples the last of those ticks, and not before.
- R4: A timeout pulse keeps both outputs at 0 for exactly `FIRE_CYCLES` clock cycles.
- R5: After a timeout pulse ends, the tick count restarts from zero, so a new pulse needs a full `TIMEOUT_TICKS` ticks.
- R6: A kick in the run state clears the tick count.
- R7: A kick is a cycle where `cpu_wr`=1 and `cpu_addr` equals `KICK_ADDR` on every bit. A write to any other address, or the matching address with `cpu_wr`=0, does not clear the count.
- R8: When a kick and a tick fall in the same cycle, the kick wins and the count becomes zero.
- R9: With `wd_en`=0 no timeout pulse occurs, whatever the number of ticks, and the count is held at zero. After `wd_en` returns to 1, a full `TIMEOUT_TICKS` ticks are needed.
- R10: The power-on pulse of R2 happens with the same length when `wd_en`=0.
- R11: `cpu_halt_n` equals `cpu_reset_n` in every cycle.
- R12: Kicks during a power-on or timeout pulse neither shorten nor lengthen it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous power-on reset, active high |
| frame_tick | input | 1 | One-cycle frame-rate tick that advances the timeout count |
| cpu_addr | input | ADDR_W | Processor address bus |
| cpu_wr | input | 1 | Processor write strobe, one cycle per write |
| wd_en | input | 1 | Watchdog timeout enable strap, high when left open |
| cpu_halt_n | output | 1 | Processor halt, active low |
| cpu_reset_n | output | 1 | Processor reset, active low |

## Verification
The bench builds the block with `TIMEOUT_TICKS`=4, `POR_CYCLES`=6, `FIRE_CYCLES`=5 and a 23-bit kick address of `23'h2A5A5A`. With these values every tick window and every pulse edge falls within a few dozen cycles. The bench can therefore check each boundary exactly: the cycle before the last tick, the last tick itself, and the first and last low cycles of each pulse. Because the two pulse lengths differ, a design that uses the wrong length for one of the pulses gives a result the bench can see. The wrong-address kick differs from the kick address only in its lowest bit, which checks that the address compare covers every bit.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    typedef enum logic [1:0] {
        ST_POR  = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIRE = 2'd2
    } wdog_state_e;

endpackage

// File: rtl/wdog_kick_decode.sv
module wdog_kick_decode #(
    parameter int                ADDR_W    = 23,
    parameter logic [ADDR_W-1:0] KICK_ADDR = 23'h180000
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    output logic              kick_o
);

    logic addr_hit;

    // Full-width compare: every address bit must match.
    assign addr_hit = (addr_i == KICK_ADDR);
    assign kick_o   = wr_i & addr_hit;

endmodule

// File: rtl/wdog_timeout_cnt.sv
module wdog_timeout_cnt #(
    parameter int TIMEOUT_TICKS = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic arm_i,
    input  logic tick_i,
    input  logic kick_i,
    output logic expire_o
);

    localparam int CW = $clog2(TIMEOUT_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT_TICKS - 1);

    logic [CW-1:0] cnt_q;

    // The count is held at zero while disarmed. A kick wins over a tick.
    always_ff @(posedge clk) begin
        if (rst || !arm_i) begin
            cnt_q <= '0;
        end else if (kick_i) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expire_o = arm_i && tick_i && !kick_i && (cnt_q == LAST);

endmodule

// File: rtl/wdog_pulse_timer.sv
module wdog_pulse_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run_i,
    input  logic [CW-1:0] last_i,
    output logic          done_o
);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done_o = run_i && (cnt_q == last_i);

endmodule

// File: rtl/wdog_rst_gen.sv
module wdog_rst_gen
    import wdog_pkg::*;
#(
    parameter int                ADDR_W        = 23,
    parameter logic [ADDR_W-1:0] KICK_ADDR     = 23'h180000,
    parameter int                TIMEOUT_TICKS = 8,
    parameter int                POR_CYCLES    = 64,
    parameter int                FIRE_CYCLES   = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_tick,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_wr,
    input  logic              wd_en,
    output logic              cpu_halt_n,
    output logic              cpu_reset_n
);

    localparam int MAX_PULSE = (POR_CYCLES > FIRE_CYCLES) ? POR_CYCLES : FIRE_CYCLES;
    localparam int PCW       = $clog2(MAX_PULSE + 1);
    localparam logic [PCW-1:0] POR_LAST  = PCW'(POR_CYCLES - 1);
    localparam logic [PCW-1:0] FIRE_LAST = PCW'(FIRE_CYCLES - 1);

    wdog_state_e   state_q, state_d;
    logic          kick;
    logic          expire;
    logic          pulse_run;
    logic          pulse_done;
    logic          arm;
    logic [PCW-1:0] pulse_last;
    logic          hold_low;

    wdog_kick_decode #(
        .ADDR_W    (ADDR_W),
        .KICK_ADDR (KICK_ADDR)
    ) u_kick (
        .addr_i (cpu_addr),
        .wr_i   (cpu_wr),
        .kick_o (kick)
    );

    assign arm = (state_q == ST_RUN) && wd_en;

    wdog_timeout_cnt #(
        .TIMEOUT_TICKS (TIMEOUT_TICKS)
    ) u_tmo (
        .clk      (clk),
        .rst      (rst),
        .arm_i    (arm),
        .tick_i   (frame_tick),
        .kick_i   (kick),
        .expire_o (expire)
    );

    assign pulse_run  = (state_q == ST_POR) || (state_q == ST_FIRE);
    assign pulse_last = (state_q == ST_POR) ? POR_LAST : FIRE_LAST;

    wdog_pulse_timer #(
        .CW (PCW)
    ) u_pulse (
        .clk    (clk),
        .rst    (rst),
        .run_i  (pulse_run),
        .last_i (pulse_last),
        .done_o (pulse_done)
    );

    // Next-state logic: POR_DONE, EXPIRE, FIRE_DONE.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_POR:  if (pulse_done) state_d = ST_RUN;
            ST_RUN:  if (expire)     state_d = ST_FIRE;
            ST_FIRE: if (pulse_done) state_d = ST_RUN;
            default:                 state_d = ST_POR;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_POR;
        end else begin
            state_q <= state_d;
        end
    end

    // Output decode: both lines are driven from one term.
    always_comb begin
        hold_low    = (state_q != ST_RUN);
        cpu_reset_n = !hold_low;
        cpu_halt_n  = !hold_low;
    end

endmodule

// File: rtl/wdog_rst_gen_chk.sv
module wdog_rst_gen_chk #(
    parameter int                ADDR_W        = 23,
    parameter logic [ADDR_W-1:0] KICK_ADDR     = 23'h180000,
    parameter int                POR_CYCLES    = 64,
    parameter int                FIRE_CYCLES   = 64
) (
    input logic              clk,
    input logic              rst,
    input logic              frame_tick,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              cpu_wr,
    input logic              wd_en,
    input logic              cpu_halt_n,
    input logic              cpu_reset_n
);

    int   low_run;
    logic from_por;

    // Length of the current low run, and whether it began at power-on.
    always_ff @(posedge clk) begin
        if (rst) begin
            low_run  <= 0;
            from_por <= 1'b1;
        end else if (!cpu_reset_n) begin
            low_run  <= low_run + 1;
        end else begin
            low_run  <= 0;
            from_por <= 1'b0;
        end
    end

    a_r1_reset_holds_low: assert property (@(posedge clk)
        rst |=> !cpu_reset_n);

    a_r11_lines_paired: assert property (@(posedge clk)
        cpu_halt_n == cpu_reset_n);

    a_r2_por_length: assert property (@(posedge clk) disable iff (rst)
        ($rose(cpu_reset_n) && from_por) |-> (low_run == POR_CYCLES));

    a_r4_fire_length: assert property (@(posedge clk) disable iff (rst)
        ($rose(cpu_reset_n) && !from_por) |-> (low_run == FIRE_CYCLES));

    a_r3_fire_needs_tick: assert property (@(posedge clk) disable iff (rst)
        (cpu_reset_n && !frame_tick) |=> cpu_reset_n);

    a_r6_kick_keeps_alive: assert property (@(posedge clk) disable iff (rst)
        (cpu_reset_n && cpu_wr && (cpu_addr == KICK_ADDR)) |=> cpu_reset_n);

    a_r9_disabled_no_fire: assert property (@(posedge clk) disable iff (rst)
        (cpu_reset_n && !wd_en) |=> cpu_reset_n);

endmodule

bind wdog_rst_gen wdog_rst_gen_chk #(
    .ADDR_W      (ADDR_W),
    .KICK_ADDR   (KICK_ADDR),
    .POR_CYCLES  (POR_CYCLES),
    .FIRE_CYCLES (FIRE_CYCLES)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .frame_tick  (frame_tick),
    .cpu_addr    (cpu_addr),
    .cpu_wr      (cpu_wr),
    .wd_en       (wd_en),
    .cpu_halt_n  (cpu_halt_n),
    .cpu_reset_n (cpu_reset_n)
);

// File: tb/wdog_rst_gen_tb.sv
`timescale 1ns/1ps
module wdog_rst_gen_tb;

    localparam int          ADDR_W  = 23;
    localparam logic [22:0] KADDR   = 23'h2A5A5A;
    localparam int          TMO     = 4;
    localparam int          POR_N   = 6;
    localparam int          FIRE_N  = 5;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              frame_tick = 1'b0;
    logic [ADDR_W-1:0] cpu_addr = '0;
    logic              cpu_wr = 1'b0;
    logic              wd_en = 1'b1;
    logic              cpu_halt_n;
    logic              cpu_reset_n;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #2 clk = ~clk;

    wdog_rst_gen #(
        .ADDR_W        (ADDR_W),
        .KICK_ADDR     (KADDR),
        .TIMEOUT_TICKS (TMO),
        .POR_CYCLES    (POR_N),
        .FIRE_CYCLES   (FIRE_N)
    ) u_dut (
        .clk         (clk),
        .rst         (rst),
        .frame_tick  (frame_tick),
        .cpu_addr    (cpu_addr),
        .cpu_wr      (cpu_wr),
        .wd_en       (wd_en),
        .cpu_halt_n  (cpu_halt_n),
        .cpu_reset_n (cpu_reset_n)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // exp_rn: expected level of both active-low outputs.
    task automatic expect_out(input logic exp_rn, input string req);
        n_chk++;
        if (cpu_reset_n !== exp_rn) begin
            n_bad++;
            $display("FAIL %s: cpu_reset_n actual=%0b expected=%0b at %0t", req, cpu_reset_n, exp_rn, $time);
        end
        n_chk++;
        if (cpu_halt_n !== exp_rn) begin
            n_bad++;
            $display("FAIL R11 (%s): cpu_halt_n actual=%0b expected=%0b at %0t", req, cpu_halt_n, exp_rn, $time);
        end
    endtask

    task automatic tick();
        frame_tick = 1'b1;
        step();
        frame_tick = 1'b0;
    endtask

    task automatic write(input logic [ADDR_W-1:0] a, input logic strobe);
        cpu_addr = a;
        cpu_wr   = strobe;
        step();
        cpu_wr   = 1'b0;
        cpu_addr = '0;
    endtask

    // Ticks that must not yet cause a pulse.
    task automatic safe_ticks(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            tick();
            expect_out(1'b1, req);
        end
    endtask

    // The pulse began at the last edge; check its length.
    task automatic check_pulse(input int len, input string req);
        expect_out(1'b0, req);
        for (int i = 1; i < len; i++) begin
            step();
            expect_out(1'b0, req);
        end
        step();
        expect_out(1'b1, req);
    endtask

    task automatic t_reset(input string req);
        rst = 1'b1;
        step();
        step();
        expect_out(1'b0, "R1");
        rst = 1'b0;
        for (int i = 1; i < POR_N; i++) begin
            step();
            expect_out(1'b0, req);
        end
        step();
        expect_out(1'b1, req);
    endtask

    task automatic t_timeout();
        safe_ticks(TMO - 1, "R3");
        tick();
        check_pulse(FIRE_N, "R4");
        // R5: the window restarts from zero.
        safe_ticks(TMO - 1, "R5");
        tick();
        check_pulse(FIRE_N, "R5");
    endtask

    task automatic t_kick();
        safe_ticks(TMO - 1, "R6");
        write(KADDR, 1'b1);
        expect_out(1'b1, "R6");
        safe_ticks(TMO - 1, "R6");
        tick();
        check_pulse(FIRE_N, "R6");
    endtask

    task automatic t_addr();
        safe_ticks(TMO - 1, "R7");
        write(KADDR ^ 23'h1, 1'b1);
        expect_out(1'b1, "R7");
        write(KADDR, 1'b0);
        expect_out(1'b1, "R7");
        tick();
        check_pulse(FIRE_N, "R7");
    endtask

    task automatic t_same_cycle();
        safe_ticks(TMO - 1, "R8");
        cpu_addr   = KADDR;
        cpu_wr     = 1'b1;
        frame_tick = 1'b1;
        step();
        cpu_wr     = 1'b0;
        frame_tick = 1'b0;
        expect_out(1'b1, "R8");
        safe_ticks(TMO - 1, "R8");
        tick();
        check_pulse(FIRE_N, "R8");
    endtask

    task automatic t_disable();
        safe_ticks(TMO - 1, "R9");
        wd_en = 1'b0;
        safe_ticks(3 * TMO, "R9");
        wd_en = 1'b1;
        safe_ticks(TMO - 1, "R9");
        tick();
        check_pulse(FIRE_N, "R9");
    endtask

    task automatic t_kick_in_pulse();
        safe_ticks(TMO - 1, "R12");
        tick();
        expect_out(1'b0, "R12");
        for (int i = 1; i < FIRE_N; i++) begin
            write(KADDR, 1'b1);
            expect_out(1'b0, "R12");
        end
        write(KADDR, 1'b1);
        expect_out(1'b1, "R12");
    endtask

    initial begin
        t_reset("R2");
        t_timeout();
        t_kick();
        t_addr();
        t_same_cycle();
        t_disable();
        t_kick_in_pulse();
        wd_en = 1'b0;
        t_reset("R10");
        wd_en = 1'b1;
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule